// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block is the buffering and event layer of an SPI controller. It holds a transmit queue filled from a register bus and drained by the serial shift engine, and a receive queue filled by the shift engine and drained by the bus. It reports how full each queue is and builds a six-bit status word. Level thresholds drive two interrupt sources that track the levels. Overflow and underflow events are kept as sticky bits until software clears them. A mask gates all five sources onto one interrupt line. Two DMA request lines compare the levels against their own watermarks.

The register bus is a single-cycle strobe interface. `reg_wr` and `reg_rd` are qualified by a 4-bit word address. Read data is combinational from the current state. A read of the receive data address pops one entry in that same cycle. Word addresses are: 0 transmit data (write), 1 receive data (read), 2 transmit level, 3 receive level, 4 transmit threshold, 5 receive threshold, 6 status, 7 mask, 8 raw interrupts, 9 masked interrupts, 10 clear (write), 11 DMA control, 12 transmit DMA watermark, 13 receive DMA watermark.

The shift engine reaches the queues through `sh_tx_pop`/`sh_tx_data` and `sh_rx_push`/`sh_rx_data`. Both queues are 32 deep when `VERSION` is 0 and 64 deep otherwise. While `enable` is low both queues are held empty.

Top module: `spi_fifo_stat_irq`

## Requirements
- R1: After reset the level registers (addr 2, 3) read 0, status (addr 6) reads 0x0C, mask (addr 7) reads 0, raw interrupts (addr 8) read 0x11 (thresholds reset to 0), and `irq` is low.
- R2: Each write to address 0 while enabled adds one entry and raises the transmit level by one. `sh_tx_data` shows the oldest entry, and `sh_tx_pop` removes it, so entries leave in write order. Status bit1 is set when the transmit level equals the depth.
- R3: A write to address 0 when the transmit queue is full is dropped and sets raw bit1. The bit stays set until it is cleared.
- R4: Each `sh_rx_push` while enabled adds one entry and raises the receive level by one. Reads of address 1 return the entries in push order, each read popping one. Status bit4 is set when the receive level equals the depth.
- R5: A read of address 1 with an empty receive queue, while enabled, returns 0 and sets sticky raw bit2.
- R6: A push into a full receive queue is dropped, leaves the level at the depth, and sets sticky raw bit3.
- R7: A write to address 10 clears sticky bits as follows: data bit1 clears raw bit2, data bit2 clears raw bit3, data bit3 clears raw bit1, and data bit0 clears all three. Raw bits 0 and 4 are unaffected.
- R8: Raw bit0 equals (transmit level <= addr 4 value). Raw bit4 equals (receive level >= addr 5 value).
- R9: Address 9 reads raw AND mask. `irq` is high exactly when that value is nonzero.
- R10: `dma_tx_req` is addr 11 bit1 AND (transmit level <= addr 12 value). `dma_rx_req` is addr 11 bit0 AND (receive level >= addr 13 value).
- R11: While `enable` is low both queues are emptied, both levels read 0, and writes to address 0 are dropped without setting raw bit1.
- R12: The queue depth is 32 for `VERSION` 0 and 64 for any other value.
- R13: Status bit0 is `sh_busy` OR (enabled AND transmit queue not empty). Bit5 is `sh_tgt_busy`. Bit2 is transmit empty and bit3 is receive empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; low flushes both queues |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| sh_tx_pop | input | 1 | Shift engine takes the oldest transmit entry |
| sh_tx_data | output | DW | Oldest transmit entry, 0 when empty |
| sh_rx_push | input | 1 | Shift engine stores a received word |
| sh_rx_data | input | DW | Received word |
| sh_busy | input | 1 | Shift engine is moving a frame |
| sh_tgt_busy | input | 1 | Shift engine busy transmitting in target mode |
| irq | output | 1 | OR of masked interrupt bits |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The bench fills each queue one entry at a time to exactly the depth and checks the level after every step. It then pushes once more. A design that wraps the count or lets the write through would show a level of 0 or a corrupted oldest entry, and no overflow bit. Each clear bit is applied on its own, and every mask value is swept against a mixed raw pattern. A clear decoder with swapped bits, or a mask applied as OR, would show up as a wrong masked word. Threshold and watermark comparisons are swept across levels 0 to 9. This catches an off-by-one between "at or below" and "below". A second instance with the larger depth must accept 64 entries where the default one stops at 32.

// File: rtl/spifs_pkg.sv
package spifs_pkg;
  localparam logic [3:0] A_TXD   = 4'd0;
  localparam logic [3:0] A_RXD   = 4'd1;
  localparam logic [3:0] A_TXLVL = 4'd2;
  localparam logic [3:0] A_RXLVL = 4'd3;
  localparam logic [3:0] A_TXTHR = 4'd4;
  localparam logic [3:0] A_RXTHR = 4'd5;
  localparam logic [3:0] A_STAT  = 4'd6;
  localparam logic [3:0] A_MASK  = 4'd7;
  localparam logic [3:0] A_RAW   = 4'd8;
  localparam logic [3:0] A_MSKST = 4'd9;
  localparam logic [3:0] A_CLR   = 4'd10;
  localparam logic [3:0] A_DMACT = 4'd11;
  localparam logic [3:0] A_DTXWM = 4'd12;
  localparam logic [3:0] A_DRXWM = 4'd13;

  // R12: depth selected by the variant number
  function automatic int depth_of(input int ver);
    return (ver != 0) ? 64 : 32;
  endfunction

  function automatic logic at_or_below(input logic [15:0] lvl, input logic [15:0] mark);
    return lvl <= mark;
  endfunction

  function automatic logic at_or_above(input logic [15:0] lvl, input logic [15:0] mark);
    return lvl >= mark;
  endfunction
endpackage

// File: rtl/spifs_fifo.sv
module spifs_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == LW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign level   = cnt;
  assign rdata   = empty ? '0 : mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      cnt <= cnt + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end
endmodule

// File: rtl/spifs_mark.sv
module spifs_mark #(
  parameter int LW = 6
) (
  input  logic          tx_gate,
  input  logic          rx_gate,
  input  logic [LW-1:0] tx_lvl,
  input  logic [LW-1:0] tx_mark,
  input  logic [LW-1:0] rx_lvl,
  input  logic [LW-1:0] rx_mark,
  output logic          tx_hit,
  output logic          rx_hit
);
  import spifs_pkg::*;
  assign tx_hit = tx_gate && at_or_below(16'(tx_lvl), 16'(tx_mark));
  assign rx_hit = rx_gate && at_or_above(16'(rx_lvl), 16'(rx_mark));
endmodule

// File: rtl/spifs_irq.sv
module spifs_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tov_ev,
  input  logic       run_ev,
  input  logic       rov_ev,
  input  logic       clr_we,
  input  logic [3:0] clr_bits,
  input  logic       tx_low,
  input  logic       rx_high,
  input  logic [4:0] mask,
  output logic [4:0] raw,
  output logic [4:0] masked,
  output logic       irq
);
  logic s_tov, s_run, s_rov;
  logic k_tov, k_run, k_rov;

  // R7: per-bit clear plus clear-all
  assign k_tov = clr_we && (clr_bits[0] || clr_bits[3]);
  assign k_run = clr_we && (clr_bits[0] || clr_bits[1]);
  assign k_rov = clr_we && (clr_bits[0] || clr_bits[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_tov <= 1'b0;
      s_run <= 1'b0;
      s_rov <= 1'b0;
    end else begin
      s_tov <= tov_ev || (s_tov && !k_tov);
      s_run <= run_ev || (s_run && !k_run);
      s_rov <= rov_ev || (s_rov && !k_rov);
    end
  end

  assign raw    = {rx_high, s_rov, s_run, s_tov, tx_low};
  assign masked = raw & mask;
  assign irq    = |masked;
endmodule

// File: rtl/spi_fifo_stat_irq.sv
module spi_fifo_stat_irq #(
  parameter int DW      = 16,
  parameter int VERSION = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [3:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          sh_tx_pop,
  output logic [DW-1:0] sh_tx_data,
  input  logic          sh_rx_push,
  input  logic [DW-1:0] sh_rx_data,
  input  logic          sh_busy,
  input  logic          sh_tgt_busy,
  output logic          irq,
  output logic          dma_tx_req,
  output logic          dma_rx_req
);
  import spifs_pkg::*;

  localparam int DEPTH = depth_of(VERSION);
  localparam int LW    = $clog2(DEPTH + 1);

  logic [LW-1:0] tx_lvl, rx_lvl;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [DW-1:0] rx_head;
  logic          tx_push_req, tx_ovf_ev;
  logic          rx_push_req, rx_ovf_ev;
  logic          rx_pop_req, rx_unf_ev;
  logic          tx_pop_req;
  logic          clr_we;
  logic [3:0]    clr_bits;
  logic [LW-1:0] tx_thr, rx_thr, dtx_wm, drx_wm;
  logic [4:0]    mask;
  logic [1:0]    dma_ctl;
  logic          thr_tx_low, thr_rx_high;
  logic [4:0]    raw, masked;
  logic [5:0]    stat;
  logic          busy;

  // bus-side events, named for the checker
  assign tx_push_req = enable && reg_wr && (reg_addr == A_TXD);
  assign tx_ovf_ev   = tx_push_req && tx_full;
  assign rx_pop_req  = enable && reg_rd && (reg_addr == A_RXD);
  assign rx_unf_ev   = rx_pop_req && rx_empty;
  assign rx_push_req = enable && sh_rx_push;
  assign rx_ovf_ev   = rx_push_req && rx_full;
  assign tx_pop_req  = enable && sh_tx_pop;
  assign clr_we      = reg_wr && (reg_addr == A_CLR);
  assign clr_bits    = reg_wdata[3:0];

  spifs_fifo #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(!enable),
    .push(tx_push_req), .wdata(reg_wdata),
    .pop(tx_pop_req), .rdata(sh_tx_data),
    .level(tx_lvl), .full(tx_full), .empty(tx_empty)
  );

  spifs_fifo #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(!enable),
    .push(rx_push_req), .wdata(sh_rx_data),
    .pop(rx_pop_req), .rdata(rx_head),
    .level(rx_lvl), .full(rx_full), .empty(rx_empty)
  );

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr  <= '0;
      rx_thr  <= '0;
      dtx_wm  <= '0;
      drx_wm  <= '0;
      mask    <= '0;
      dma_ctl <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_TXTHR: tx_thr  <= reg_wdata[LW-1:0];
        A_RXTHR: rx_thr  <= reg_wdata[LW-1:0];
        A_DTXWM: dtx_wm  <= reg_wdata[LW-1:0];
        A_DRXWM: drx_wm  <= reg_wdata[LW-1:0];
        A_MASK:  mask    <= reg_wdata[4:0];
        A_DMACT: dma_ctl <= reg_wdata[1:0];
        default: ;
      endcase
    end
  end

  // R8: level-following threshold sources
  spifs_mark #(.LW(LW)) u_thr (
    .tx_gate(1'b1), .rx_gate(1'b1),
    .tx_lvl(tx_lvl), .tx_mark(tx_thr),
    .rx_lvl(rx_lvl), .rx_mark(rx_thr),
    .tx_hit(thr_tx_low), .rx_hit(thr_rx_high)
  );

  // R10: DMA requests against their own watermarks
  spifs_mark #(.LW(LW)) u_dma (
    .tx_gate(dma_ctl[1]), .rx_gate(dma_ctl[0]),
    .tx_lvl(tx_lvl), .tx_mark(dtx_wm),
    .rx_lvl(rx_lvl), .rx_mark(drx_wm),
    .tx_hit(dma_tx_req), .rx_hit(dma_rx_req)
  );

  spifs_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .tov_ev(tx_ovf_ev), .run_ev(rx_unf_ev), .rov_ev(rx_ovf_ev),
    .clr_we(clr_we), .clr_bits(clr_bits),
    .tx_low(thr_tx_low), .rx_high(thr_rx_high),
    .mask(mask), .raw(raw), .masked(masked), .irq(irq)
  );

  // R13: status word
  assign busy = sh_busy || (enable && !tx_empty);
  assign stat = {sh_tgt_busy, rx_full, rx_empty, tx_empty, tx_full, busy};

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_RXD:   reg_rdata = rx_head;
      A_TXLVL: reg_rdata = DW'(tx_lvl);
      A_RXLVL: reg_rdata = DW'(rx_lvl);
      A_TXTHR: reg_rdata = DW'(tx_thr);
      A_RXTHR: reg_rdata = DW'(rx_thr);
      A_STAT:  reg_rdata = DW'(stat);
      A_MASK:  reg_rdata = DW'(mask);
      A_RAW:   reg_rdata = DW'(raw);
      A_MSKST: reg_rdata = DW'(masked);
      A_DMACT: reg_rdata = DW'(dma_ctl);
      A_DTXWM: reg_rdata = DW'(dtx_wm);
      A_DRXWM: reg_rdata = DW'(drx_wm);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spifs_checker.sv
module spifs_checker #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  parameter int LW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic [LW-1:0] tx_lvl,
  input logic [LW-1:0] rx_lvl,
  input logic [4:0]    raw,
  input logic          tx_ovf_ev,
  input logic          rx_ovf_ev,
  input logic          rx_unf_ev,
  input logic          clr_we,
  input logic [3:0]    clr_bits,
  input logic          rx_pop_req,
  input logic [DW-1:0] reg_rdata,
  input logic          irq,
  input logic [4:0]    mask,
  input logic [1:0]    dma_ctl,
  input logic          dma_tx_req,
  input logic          dma_rx_req
);
  assert_lvl_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_lvl <= LW'(DEPTH)) && (rx_lvl <= LW'(DEPTH)));

  assert_tov_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    raw[1] && !(clr_we && (clr_bits[0] || clr_bits[3])) |=> raw[1]);

  assert_tov_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw[1]) |-> $past(tx_ovf_ev));

  assert_unf_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_unf_ev |-> (reg_rdata == '0));

  assert_rov_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf_ev && !rx_pop_req && enable |=> (rx_lvl == LW'(DEPTH)) || !enable);

  assert_clr_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we && clr_bits[0] && !tx_ovf_ev && !rx_ovf_ev && !rx_unf_ev |=> (raw[3:1] == 3'b000));

  assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask != '0));

  assert_dma_tx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_tx_req |-> dma_ctl[1]);

  assert_dma_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rx_req |-> dma_ctl[0]);

  assert_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (tx_lvl == '0) && (rx_lvl == '0));
endmodule

bind spi_fifo_stat_irq spifs_checker #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .raw(raw),
  .tx_ovf_ev(tx_ovf_ev), .rx_ovf_ev(rx_ovf_ev), .rx_unf_ev(rx_unf_ev),
  .clr_we(clr_we), .clr_bits(clr_bits), .rx_pop_req(rx_pop_req),
  .reg_rdata(reg_rdata), .irq(irq), .mask(mask), .dma_ctl(dma_ctl),
  .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
);

// File: tb/tb_spi_fifo_stat_irq.sv
`timescale 1ns/1ps
module tb_spi_fifo_stat_irq;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] rdata, rdata2, tx_data, tx_data2;
  logic sh_tx_pop = 1'b0, sh_rx_push = 1'b0, sh_busy = 1'b0, sh_tgt_busy = 1'b0;
  logic [DW-1:0] sh_rx_data = '0;
  logic irq, dma_tx_req, dma_rx_req, irq2, dtx2, drx2;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  spi_fifo_stat_irq #(.DW(DW), .VERSION(0)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata),
    .sh_tx_pop(sh_tx_pop), .sh_tx_data(tx_data), .sh_rx_push(sh_rx_push),
    .sh_rx_data(sh_rx_data), .sh_busy(sh_busy), .sh_tgt_busy(sh_tgt_busy),
    .irq(irq), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req));

  spi_fifo_stat_irq #(.DW(DW), .VERSION(1)) dut_v2 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata2),
    .sh_tx_pop(sh_tx_pop), .sh_tx_data(tx_data2), .sh_rx_push(sh_rx_push),
    .sh_rx_data(sh_rx_data), .sh_busy(sh_busy), .sh_tgt_busy(sh_tgt_busy),
    .irq(irq2), .dma_tx_req(dtx2), .dma_rx_req(drx2));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v, output int v2);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #2;
    v = int'(rdata); v2 = int'(rdata2);
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic tx_pop(output int v);
    @(negedge clk);
    sh_tx_pop = 1'b1;
    #2 v = int'(tx_data);
    @(posedge clk); #1;
    sh_tx_pop = 1'b0;
  endtask

  task automatic rx_push(input logic [DW-1:0] d);
    @(negedge clk);
    sh_rx_push = 1'b1; sh_rx_data = d;
    @(posedge clk); #1;
    sh_rx_push = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int v, v2;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(spifs_pkg::A_TXLVL, v, v2); check("R1 tx level", v, 0);
    rd(spifs_pkg::A_RXLVL, v, v2); check("R1 rx level", v, 0);
    rd(spifs_pkg::A_STAT, v, v2);  check("R1 status", v, 'h0C);
    rd(spifs_pkg::A_MASK, v, v2);  check("R1 mask", v, 0);
    rd(spifs_pkg::A_RAW, v, v2);   check("R1 raw", v, 'h11);
    check("R1 irq", int'(irq), 0);

    @(negedge clk) enable = 1'b1;

    // R2 fill transmit queue, level after every write
    for (int i = 0; i < 32; i++) begin
      wr(spifs_pkg::A_TXD, DW'(i * 3 + 1));
      rd(spifs_pkg::A_TXLVL, v, v2); check("R2 tx level", v, i + 1);
    end
    rd(spifs_pkg::A_STAT, v, v2); check("R2 status full", v, 'h0B);
    // R3 overflow
    wr(spifs_pkg::A_TXD, 16'h7777);
    rd(spifs_pkg::A_TXLVL, v, v2); check("R3 level kept", v, 32);
    rd(spifs_pkg::A_RAW, v, v2);   check("R3 raw overflow", v, 'h12);
    // R2 drain in order
    for (int i = 0; i < 32; i++) begin
      tx_pop(v); check("R2 tx order", v, i * 3 + 1);
    end
    rd(spifs_pkg::A_TXLVL, v, v2); check("R2 tx drained", v, 0);
    rd(spifs_pkg::A_RAW, v, v2);   check("R3 raw sticky", v, 'h13);

    // R4 fill receive queue
    for (int i = 0; i < 32; i++) begin
      rx_push(DW'(16'h100 + i * 5));
      rd(spifs_pkg::A_RXLVL, v, v2); check("R4 rx level", v, i + 1);
    end
    rd(spifs_pkg::A_STAT, v, v2); check("R4 status full", v, 'h14);
    // R6 overflow
    rx_push(16'hDEAD);
    rd(spifs_pkg::A_RXLVL, v, v2); check("R6 level kept", v, 32);
    rd(spifs_pkg::A_RAW, v, v2);   check("R6 raw overflow", v, 'h1B);
    for (int i = 0; i < 32; i++) begin
      rd(spifs_pkg::A_RXD, v, v2); check("R4 rx order", v, 'h100 + i * 5);
    end
    rd(spifs_pkg::A_RXLVL, v, v2); check("R4 rx drained", v, 0);
    // R5 underflow
    rd(spifs_pkg::A_RXD, v, v2); check("R5 empty read", v, 0);
    rd(spifs_pkg::A_RAW, v, v2); check("R5 raw underflow", v, 'h1F);

    // R7 individual clears
    wr(spifs_pkg::A_CLR, 16'h2);
    rd(spifs_pkg::A_RAW, v, v2); check("R7 clear underflow", v, 'h1B);

    // R9 mask sweep against raw 0x1B
    for (int m = 0; m < 32; m++) begin
      wr(spifs_pkg::A_MASK, DW'(m));
      rd(spifs_pkg::A_MSKST, v, v2); check("R9 masked", v, m & 'h1B);
      check("R9 irq", int'(irq), ((m & 'h1B) != 0) ? 1 : 0);
    end
    wr(spifs_pkg::A_MASK, 16'h0);
    check("R9 irq off", int'(irq), 0);

    wr(spifs_pkg::A_CLR, 16'h4);
    rd(spifs_pkg::A_RAW, v, v2); check("R7 clear rx overflow", v, 'h13);
    wr(spifs_pkg::A_CLR, 16'h8);
    rd(spifs_pkg::A_RAW, v, v2); check("R7 clear tx overflow", v, 'h11);
    rd(spifs_pkg::A_RXD, v, v2);
    rd(spifs_pkg::A_RAW, v, v2); check("R5 underflow again", v, 'h15);
    wr(spifs_pkg::A_CLR, 16'h1);
    rd(spifs_pkg::A_RAW, v, v2); check("R7 clear all", v, 'h11);
    wr(spifs_pkg::A_CLR, 16'hF);
    rd(spifs_pkg::A_RAW, v, v2); check("R7 level bits kept", v, 'h11);

    // R8 / R10 sweep of levels 0..8
    wr(spifs_pkg::A_TXTHR, 16'd4);
    wr(spifs_pkg::A_RXTHR, 16'd5);
    wr(spifs_pkg::A_DTXWM, 16'd3);
    wr(spifs_pkg::A_DRXWM, 16'd6);
    wr(spifs_pkg::A_DMACT, 16'd3);
    for (int n = 0; n <= 8; n++) begin
      rd(spifs_pkg::A_RAW, v, v2);
      check("R8 tx threshold", v & 1, (n <= 4) ? 1 : 0);
      check("R8 rx threshold", (v >> 4) & 1, (n >= 5) ? 1 : 0);
      check("R10 dma tx", int'(dma_tx_req), (n <= 3) ? 1 : 0);
      check("R10 dma rx", int'(dma_rx_req), (n >= 6) ? 1 : 0);
      wr(spifs_pkg::A_TXD, DW'(n));
      rx_push(DW'(n));
    end
    check("R10 dma rx at 9", int'(dma_rx_req), 1);
    wr(spifs_pkg::A_DMACT, 16'd0);
    check("R10 dma rx gated", int'(dma_rx_req), 0);
    wr(spifs_pkg::A_DTXWM, 16'd20);
    check("R10 dma tx gated", int'(dma_tx_req), 0);
    wr(spifs_pkg::A_DMACT, 16'd2);
    check("R10 dma tx on", int'(dma_tx_req), 1);

    // R11 disable flushes, writes dropped without overflow
    @(negedge clk) enable = 1'b0;
    rd(spifs_pkg::A_TXLVL, v, v2); check("R11 tx flushed", v, 0);
    rd(spifs_pkg::A_RXLVL, v, v2); check("R11 rx flushed", v, 0);
    wr(spifs_pkg::A_TXD, 16'h55);
    rd(spifs_pkg::A_TXLVL, v, v2); check("R11 write dropped", v, 0);
    rd(spifs_pkg::A_RAW, v, v2);   check("R11 no overflow", v, 'h01);
    @(negedge clk) enable = 1'b1;
    rd(spifs_pkg::A_TXLVL, v, v2); check("R11 still empty", v, 0);

    // R13 status busy bits
    @(negedge clk) sh_busy = 1'b1;
    rd(spifs_pkg::A_STAT, v, v2); check("R13 busy input", v, 'h0D);
    @(negedge clk) begin sh_busy = 1'b0; sh_tgt_busy = 1'b1; end
    rd(spifs_pkg::A_STAT, v, v2); check("R13 target busy", v, 'h2C);
    @(negedge clk) sh_tgt_busy = 1'b0;
    wr(spifs_pkg::A_TXD, 16'h1);
    rd(spifs_pkg::A_STAT, v, v2); check("R13 busy from queue", v, 'h09);

    // R12 depth per variant
    @(negedge clk) enable = 1'b0;
    @(negedge clk) enable = 1'b1;
    for (int i = 0; i < 64; i++) wr(spifs_pkg::A_TXD, DW'(i));
    rd(spifs_pkg::A_TXLVL, v, v2);
    check("R12 depth 32", v, 32);
    check("R12 depth 64", v2, 64);
    rd(spifs_pkg::A_STAT, v, v2);
    check("R12 larger full", v2, 'h0B);

    summary();
  end
endmodule